// File: doc/BRIEF.md
# Signaling Stream Formatter

This block produces a serial signaling output that runs in step with backplane PCM data. Each channel slot is eight bits long; the upper four bit times of every slot are held at zero and the lower four carry that channel's robbed-bit or CAS signaling nibble, most significant bit first. Signaling values are written into a shadow bank at any time. On the multiframe strobe the whole shadow bank is copied into a live bank that feeds the output. Because of this, the stream changes only at multiframe rate, and a signaling freeze control can hold it unchanged.

A frame sync marks bit 1 of slot 0. Between syncs, a position counter runs through the frame on its own. On a 1.544 MHz backplane the T1 frame is 193 bit times: 24 slots followed by one framing bit. On a 2.048 MHz backplane it is 256 bit times (32 slots). For T1 on the 2.048 MHz backplane, channels 0 to 23 occupy slots 0 to 23, and slots 24 to 31 stay silent. In E1 CAS mode the frame is always 256 bit times, and the timeslots that carry framing and the CAS multiframe (slots 0 and 16) stay silent. Each slot's nibble is latched at the slot's first bit time, so a bank copy can never split a slot between old and new values.

Top module: `sig_stream_fmt`

## Requirements
- R1: While `rst_n` is low, `sig_out` and `slot_mark` are 0.
- R2: When `fsync` is high at a rising clock edge, the outputs after that edge present position 0 (bit 1 of slot 0): `slot_mark` is 1 and `sig_out` is that position's value, regardless of where the counter was.
- R3: `slot_mark` is 1 at every position that is a multiple of 8 (bit 1 of a slot) and 0 at all other positions, including position 192, the framing bit of a 193-position frame.
- R4: At positions whose index mod 8 is 0 to 3 (slot bits 1 to 4), and at the framing bit position 192, `sig_out` is 0.
- R5: With `mode` = 0 (ESF; value 3 behaves the same), slot bits 5, 6, 7 and 8 carry nibble bits 3, 2, 1 and 0 of the slot's live entry.
- R6: With `mode` = 1 (D4), slot bits 5, 6, 7 and 8 carry nibble bits 3, 2, 3 and 2 of the slot's live entry. Bit 7 therefore repeats bit 5, and bit 8 repeats bit 6.
- R7: With `mode` = 2 (E1 CAS), the frame is 256 positions and slot s carries live entry s. Slots 0 and 16 output 0.
- R8: Without `fsync`, the counter wraps to position 0 after position 192 when `wide_bp` = 0 and `mode` is not 2. Otherwise it wraps after position 255.
- R9: For T1 modes with `wide_bp` = 1, slots 0 to 23 carry live entries 0 to 23, and slots 24 to 31 output 0 whatever their entries hold.
- R10: A write (`wr_en`, `wr_chan`, `wr_sig`) changes only the shadow entry. The output follows the live bank, which takes a copy of all shadow entries at an edge where `mf_strobe` is 1.
- R11: When `freeze` is 1 at an edge where `mf_strobe` is 1, the live bank keeps its contents.
- R12: A write made at the same edge as a copy is not part of that copy. It appears after the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, marks bit 1 of slot 0 |
| mf_strobe | input | 1 | Multiframe boundary strobe, copies shadow to live |
| wr_en | input | 1 | Shadow entry write enable |
| wr_chan | input | 5 | Entry index for the write (slot index) |
| wr_sig | input | 4 | Signaling nibble, bit 3 = A, bit 0 = D |
| mode | input | 2 | 0 ESF, 1 D4, 2 E1 CAS, 3 as ESF |
| wide_bp | input | 1 | 1 selects the 32-slot (2.048 MHz) backplane |
| freeze | input | 1 | Holds the live bank across strobes |
| sig_out | output | 1 | Serial signaling bit |
| slot_mark | output | 1 | High at bit 1 of each slot |

## Verification
The assertions check the following on every cycle:
- the re-alignment after a frame sync;
- the wrap after the framing bit of a 193-position frame;
- silence in the first four bits of each slot;
- marker placement on slot boundaries;
- the D4 bit repetition;
- that the live bank moves only on an unfrozen strobe.

Only the bench's scenarios can show two further properties. The first is that each slot carries the correct entry in the correct bit order for each mode and backplane width, with the silent slots held at zero. The second is how the shadow and live banks behave across writes, including a write made at the same edge as a strobe.

// File: rtl/sig_fmt_pkg.sv
package sig_fmt_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        MODE_ESF   = 2'd0,
        MODE_D4    = 2'd1,
        MODE_E1CAS = 2'd2,
        MODE_RSVD  = 2'd3
    } sig_mode_e;

    // Select the serial bit for nibble position sel (0 = slot bit 5).
    function automatic logic pick_bit(logic [NIB_W-1:0] nib, logic [1:0] sel,
                                      sig_mode_e m);
        if (m == MODE_D4)
            return sel[0] ? nib[2] : nib[3];
        else
            return nib[2'd3 - sel];
    endfunction

endpackage

// File: rtl/sig_pos_timer.sv
module sig_pos_timer #(
    parameter int POS_W     = 8,
    parameter int FULL_LEN  = 256,
    parameter int SHORT_LEN = 193
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             long_frame,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_nxt
);

    localparam logic [POS_W-1:0] FULL_LAST  = POS_W'(FULL_LEN - 1);
    localparam logic [POS_W-1:0] SHORT_LAST = POS_W'(SHORT_LEN - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [POS_W-1:0] last;

    always_comb begin
        st_d = st_q;
        last = long_frame ? FULL_LAST : SHORT_LAST;
        if (fsync)
            st_d.pos = '0;
        else if (st_q.pos >= last)
            st_d.pos = '0;
        else
            st_d.pos = st_q.pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_q   = st_q.pos;
    assign pos_nxt = st_d.pos;

    // R2
    fsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> pos_q == '0);

    // R8
    short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_frame && pos_q == SHORT_LAST) |=> pos_q == '0);

endmodule

// File: rtl/sig_bank.sv
module sig_bank #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [sig_fmt_pkg::NIB_W-1:0] wr_nib,
    input  logic                          mf_strobe,
    input  logic                          freeze,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [sig_fmt_pkg::NIB_W-1:0] rd_nib
);
    import sig_fmt_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0][NIB_W-1:0] shadow;
        logic [ENTRIES-1:0][NIB_W-1:0] live;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mf_strobe && !freeze)
            st_d.live = st_q.shadow;
        if (wr_en)
            st_d.shadow[wr_idx] = wr_nib;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_nib = st_q.live[rd_idx];

    // R10
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_strobe |=> $stable(st_q.live));

    // R11
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(st_q.live));

endmodule

// File: rtl/sig_slot_shaper.sv
module sig_slot_shaper #(
    parameter int POS_W     = 8,
    parameter int BIT_W     = 3,
    parameter int IDX_W     = 5,
    parameter int T1_CH     = 24,
    parameter int SHORT_LEN = 193,
    parameter int CAS_SLOT  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [POS_W-1:0]              pos_nxt,
    input  logic                          long_frame,
    input  logic [1:0]                    mode,
    input  logic [sig_fmt_pkg::NIB_W-1:0] rd_nib,
    output logic                          sig_out,
    output logic                          slot_mark
);
    import sig_fmt_pkg::*;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             sig;
        logic             mark;
    } shp_t;

    shp_t st_d, st_q;
    sig_mode_e        m;
    logic [BIT_W-1:0] bit_idx;
    logic [IDX_W-1:0] slot;
    logic             slot_ok;
    logic             in_chan;

    always_comb begin
        st_d    = st_q;
        m       = sig_mode_e'(mode);
        bit_idx = pos_nxt[BIT_W-1:0];
        slot    = pos_nxt[POS_W-1:BIT_W];
        in_chan = long_frame || (int'(pos_nxt) < SHORT_LEN - 1);
        if (m == MODE_E1CAS)
            slot_ok = (slot != '0) && (int'(slot) != CAS_SLOT);
        else
            slot_ok = int'(slot) < T1_CH;
        if (bit_idx == '0)
            st_d.nib = (slot_ok && in_chan) ? rd_nib : '0;
        st_d.sig  = bit_idx[BIT_W-1] ? pick_bit(st_d.nib, bit_idx[1:0], m) : 1'b0;
        st_d.mark = (bit_idx == '0) && in_chan;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sig_out   = st_q.sig;
    assign slot_mark = st_q.mark;

endmodule

// File: rtl/sig_stream_fmt.sv
module sig_stream_fmt #(
    parameter int SLOTS  = 32,
    parameter int T1_CH  = 24,
    parameter int SLOT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic       mf_strobe,
    input  logic       wr_en,
    input  logic [4:0] wr_chan,
    input  logic [3:0] wr_sig,
    input  logic [1:0] mode,
    input  logic       wide_bp,
    input  logic       freeze,
    output logic       sig_out,
    output logic       slot_mark
);
    import sig_fmt_pkg::*;

    localparam int FULL_LEN  = SLOTS * SLOT_W;
    localparam int SHORT_LEN = T1_CH * SLOT_W + 1;
    localparam int POS_W     = $clog2(FULL_LEN);
    localparam int IDX_W     = $clog2(SLOTS);
    localparam int BIT_W     = $clog2(SLOT_W);

    logic [POS_W-1:0] pos_q, pos_nxt;
    logic [IDX_W-1:0] rd_idx;
    logic [NIB_W-1:0] rd_nib;
    logic             long_frame;

    assign long_frame = wide_bp || (mode == MODE_E1CAS);
    assign rd_idx     = pos_nxt[POS_W-1:BIT_W];

    sig_pos_timer #(.POS_W(POS_W), .FULL_LEN(FULL_LEN), .SHORT_LEN(SHORT_LEN)) u_tmr (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .long_frame(long_frame),
        .pos_q(pos_q), .pos_nxt(pos_nxt)
    );

    sig_bank #(.ENTRIES(SLOTS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_chan[IDX_W-1:0]),
        .wr_nib(wr_sig), .mf_strobe(mf_strobe), .freeze(freeze),
        .rd_idx(rd_idx), .rd_nib(rd_nib)
    );

    sig_slot_shaper #(.POS_W(POS_W), .BIT_W(BIT_W), .IDX_W(IDX_W), .T1_CH(T1_CH),
                      .SHORT_LEN(SHORT_LEN), .CAS_SLOT(SLOTS / 2)) u_shp (
        .clk(clk), .rst_n(rst_n), .pos_nxt(pos_nxt), .long_frame(long_frame),
        .mode(mode), .rd_nib(rd_nib), .sig_out(sig_out), .slot_mark(slot_mark)
    );

    // R4
    upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[BIT_W-1] == 1'b0) |-> !sig_out);

    // R3
    mark_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_mark |-> pos_q[BIT_W-1:0] == '0);

    // R6
    d4_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_D4 && $past(mode) == MODE_D4 && $past(mode, 2) == MODE_D4
         && $past(mode, 3) == MODE_D4 && pos_q[BIT_W-1:0] == 3'd6
         && $past(pos_q[BIT_W-1:0], 2) == 3'd4)
        |-> sig_out == $past(sig_out, 2));

endmodule

// File: tb/sim_sig_stream_fmt.sv
module sim_sig_stream_fmt;

    logic       clk = 1'b0;
    logic       rst_n, fsync, mf_strobe, wr_en, wide_bp, freeze;
    logic [4:0] wr_chan;
    logic [3:0] wr_sig;
    logic [1:0] mode;
    logic       sig_out, slot_mark;

    always #10 clk = ~clk;

    sig_stream_fmt u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mf_strobe(mf_strobe),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_sig(wr_sig), .mode(mode),
        .wide_bp(wide_bp), .freeze(freeze), .sig_out(sig_out), .slot_mark(slot_mark)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    logic [3:0] shd [32];
    logic [3:0] mdl [32];
    logic       cap_s [257];
    logic       cap_m [257];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int frame_len();
        return (wide_bp || mode == 2'd2) ? 256 : 193;
    endfunction

    function automatic logic exp_bit(int p);
        int s, b;
        bit ok;
        logic [3:0] d;
        if (frame_len() == 193 && p == 192) return 1'b0;
        s = p / 8;
        b = p % 8;
        if (b < 4) return 1'b0;
        ok = (mode == 2'd2) ? (s != 0 && s != 16) : (s < 24);
        if (!ok) return 1'b0;
        d = mdl[s];
        if (mode == 2'd1) return (b % 2 == 0) ? d[3] : d[2];
        return d[7 - b];
    endfunction

    function automatic logic exp_mark(int p);
        return (p % 8 == 0) && !(frame_len() == 193 && p == 192);
    endfunction

    task automatic wr(int ch, logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 5'(ch); wr_sig = v; shd[ch] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 32; i++) wr(i, 4'((i * 7 + seed) ^ (i >> 1)));
        wr(0, 4'b1011);
    endtask

    task automatic strobe();
        @(negedge clk);
        mf_strobe = 1'b1;
        @(negedge clk);
        mf_strobe = 1'b0;
        if (!freeze) mdl = shd;
    endtask

    task automatic capture(int n);
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        cap_s[0] = sig_out; cap_m[0] = slot_mark;
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            cap_s[k] = sig_out; cap_m[k] = slot_mark;
        end
    endtask

    task automatic check_frame(string dtag, int n);
        int len;
        len = frame_len();
        for (int k = 0; k < n; k++) begin
            int p;
            p = k % len;
            chk(cap_s[k] === exp_bit(p), (p % 8 < 4 || p == 192) ? "R4" : dtag,
                $sformatf("sig_out pos %0d", p), int'(cap_s[k]), int'(exp_bit(p)));
            chk(cap_m[k] === exp_mark(p), "R3", $sformatf("slot_mark pos %0d", p),
                int'(cap_m[k]), int'(exp_mark(p)));
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(sig_out === 1'b0, "R1", "sig_out in reset", int'(sig_out), 0);
        chk(slot_mark === 1'b0, "R1", "slot_mark in reset", int'(slot_mark), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_esf_narrow();
        mode = 2'd0; wide_bp = 1'b0;
        fill(3); strobe();
        capture(194);
        check_frame("R5", 193);
        // R8: counter wraps by itself after the framing bit
        chk(cap_m[193] === 1'b1, "R8", "wrap mark", int'(cap_m[193]), 1);
        chk(cap_s[193] === exp_bit(0), "R8", "wrap bit", int'(cap_s[193]), int'(exp_bit(0)));
    endtask

    task automatic t_d4();
        mode = 2'd1; wide_bp = 1'b0;
        fill(9); strobe();
        capture(193);
        check_frame("R6", 193);
    endtask

    task automatic t_e1();
        mode = 2'd2; wide_bp = 1'b0;
        fill(5); strobe();
        capture(257);
        check_frame("R7", 256);
        chk(cap_m[256] === 1'b1, "R8", "256 wrap mark", int'(cap_m[256]), 1);
        chk(cap_s[256] === exp_bit(0), "R8", "256 wrap bit", int'(cap_s[256]), int'(exp_bit(0)));
    endtask

    task automatic t_t1_wide();
        mode = 2'd0; wide_bp = 1'b1;
        fill(11);
        for (int i = 24; i < 32; i++) wr(i, 4'hF);
        strobe();
        capture(256);
        check_frame("R9", 256);
    endtask

    task automatic t_dbl_buffer();
        logic [3:0] late;
        mode = 2'd0; wide_bp = 1'b1;
        fill(1); strobe();
        fill(6);
        capture(256);
        check_frame("R10", 256);
        late = ~shd[3];
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 5'd3; wr_sig = late; mf_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; mf_strobe = 1'b0;
        mdl = shd;
        shd[3] = late;
        capture(256);
        check_frame("R12", 256);
        strobe();
        capture(256);
        check_frame("R12", 256);
    endtask

    task automatic t_freeze();
        mode = 2'd2; wide_bp = 1'b0;
        freeze = 1'b1;
        fill(13); strobe();
        capture(256);
        check_frame("R11", 256);
        freeze = 1'b0;
        strobe();
        capture(256);
        check_frame("R11", 256);
    endtask

    task automatic t_resync();
        mode = 2'd1; wide_bp = 1'b1;
        repeat (37) @(negedge clk);
        capture(16);
        chk(cap_m[0] === 1'b1, "R2", "mark after mid-frame sync", int'(cap_m[0]), 1);
        check_frame("R2", 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fsync = 1'b0; mf_strobe = 1'b0; wr_en = 1'b0;
        wr_chan = '0; wr_sig = '0; mode = 2'd0; wide_bp = 1'b0; freeze = 1'b0;
        for (int i = 0; i < 32; i++) begin shd[i] = '0; mdl[i] = '0; end
        t_reset();
        t_esf_narrow();
        t_d4();
        t_e1();
        t_t1_wide();
        t_dbl_buffer();
        t_freeze();
        t_resync();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule